// File: doc/BRIEF.md
# Pattern-Unlocked Serial Time Register Bank

This block is a serial timekeeping register bank that stays hidden behind an address window until the host proves that it knows a fixed 64-bit recognition sequence. The host sends every bit as a bus access: an access at one offset stands for a zero and an access at the next offset stands for a one. Until the whole sequence has matched, the block drives nothing but zero on its data bit.

Once the sequence has matched, the next access picks the direction. A read at the data offset starts a read transfer. The block then gives out the 64 bits of its eight BCD time registers on `rd_bit`, one bit per data read. An access at the zero or one offset instead starts a write transfer, which shifts in 64 new bits and loads all eight registers at the same moment. After 64 bits have moved in either direction, the block locks again and waits for the sequence once more.

Top module: `stealth_rtc`

## Requirements
- R1: While locked, an access at offset 0 sends key bit 0 and an access at offset 1 sends key bit 1. The block unlocks when 64 bits in a row match the bytes C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch, with each byte taken least significant bit first.
- R2: While locked, `rd_bit` is 0 for every access, including reads at the data offset (offset 4).
- R3: A key bit that does not match sends the matcher back to its first bit. Only a fresh 64-bit match unlocks.
- R4: While locked, any access at the data offset (offset 4) sends the matcher back to its first bit.
- R5: After unlock, a read (`bus_rd`=1) at offset 4 starts a read transfer. During each such read cycle, `rd_bit` shows transfer bit i, which is register i/8 bit i%8. Registers run 0..7 in this order: sub-second, seconds, minutes, hours, day of week, date, month, year.
- R6: After unlock, an access at offset 0 or 1 starts a write transfer. Each access supplies the next bit in the same bit order as R5. The eight registers change only when the 64th bit arrives, and they all change together.
- R7: After the 64th bit of a transfer in either direction, the block is locked again, and the full key is needed before the next transfer.
- R8: During a read transfer, accesses at offsets 0 and 1 have no effect. During a write transfer, accesses at offset 4 have no effect and return `rd_bit`=0.
- R9: After reset, the registers hold 01h for day of week, date and month, and 00h for all other registers.
- R10: `rd_bit` is 0 in every cycle that is not a read at offset 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | One-cycle bus access strobe |
| bus_addr | input | 3 | Offset within the window (0 zero bit, 1 one bit, 4 data) |
| bus_rd | input | 1 | High for a read access |
| rd_bit | output | 1 | Data bit 0 returned during a data read |

## Verification
The assertions assume that each bus access lasts exactly one clock with `bus_stb` high. They also assume that the offset and the read flag do not change while the strobe is high, so that every strobed cycle counts as exactly one bit event. The bench drives each access on the falling edge, holds it for one full cycle and releases it just after the rising edge, so no access is ever merged with the next or split in two. Offsets other than 0, 1 and 4 are never driven, which keeps every strobe within the three decoded meanings.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int FRAME_W  = REG_W * NUM_REGS;

    // Recognition word: the first byte sent sits in the low byte; the word repeats.
    localparam logic [31:0] KEY_WORD = 32'h5CA3_3AC5;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_ARMED,
        ST_READ,
        ST_WRITE
    } srtc_state_e;

    // Register 0 occupies the low byte so that transfer bit i equals vector bit i.
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hours;
        logic [7:0] minutes;
        logic [7:0] seconds;
        logic [7:0] subsec;
    } time_regs_t;

    localparam time_regs_t TIME_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                          dow: 8'h01, hours: 8'h00, minutes: 8'h00,
                                          seconds: 8'h00, subsec: 8'h00};

    typedef struct packed {
        logic zero;
        logic one;
        logic data;
        logic rd;
    } bus_dec_t;

    function automatic logic key_bit(input logic [31:0] idx);
        return KEY_WORD[idx[4:0]];
    endfunction

endpackage

// File: rtl/srtc_key_match.sv
module srtc_key_match #(
    parameter int KEY_BITS = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_stb,
    input  logic                        bit_val,
    input  logic                        restart,
    output logic                        hit,
    output logic [$clog2(KEY_BITS)-1:0] idx
);
    import srtc_pkg::*;

    localparam int IDX_W = $clog2(KEY_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_BITS - 1);

    logic match;

    assign match = (bit_val == key_bit(32'(idx)));
    assign hit   = bit_stb && !restart && match && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx <= '0;
        end else if (bit_stb) begin
            if (!match || idx == LAST) idx <= '0;
            else                       idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/srtc_xfer.sv
module srtc_xfer #(
    parameter int                                  NUM_REGS  = 8,
    parameter int                                  REG_W     = 8,
    parameter logic [NUM_REGS*REG_W-1:0]           RESET_VAL = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load,
    input  logic                      shift_out,
    input  logic                      shift_in,
    input  logic                      in_bit,
    output logic                      out_bit,
    output logic                      done,
    output logic                      commit,
    output logic [NUM_REGS*REG_W-1:0] regs
);
    localparam int FRAME_W = NUM_REGS * REG_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] sh_in_next;
    logic [CNT_W-1:0]   cnt;

    assign sh_in_next = {in_bit, sh[FRAME_W-1:1]};
    assign out_bit    = sh[0];
    assign done       = (shift_out || shift_in) && (cnt == LAST);
    assign commit     = shift_in && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            cnt  <= '0;
            regs <= RESET_VAL;
        end else if (load) begin
            sh  <= regs;
            cnt <= '0;
        end else if (shift_out) begin
            sh  <= sh >> 1;
            cnt <= cnt + 1'b1;
        end else if (shift_in) begin
            sh  <= sh_in_next;
            cnt <= cnt + 1'b1;
            if (commit) regs <= sh_in_next;
        end
    end
endmodule

// File: rtl/stealth_rtc.sv
module stealth_rtc #(
    parameter int          ADDR_W   = 3,
    parameter int          KEY_BITS = 64,
    parameter logic [ADDR_W-1:0] ZERO_OFS = 3'd0,
    parameter logic [ADDR_W-1:0] ONE_OFS  = 3'd1,
    parameter logic [ADDR_W-1:0] DATA_OFS = 3'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic              rd_bit
);
    import srtc_pkg::*;

    localparam int IDX_W = $clog2(KEY_BITS);

    bus_dec_t          dec;
    srtc_state_e       state, state_nx;
    logic              key_stb, key_val, restart, hit;
    logic [IDX_W-1:0]  key_idx;
    logic              shift_out, shift_in, out_bit, done, commit;
    logic [FRAME_W-1:0] regs;

    always_comb begin
        dec.zero = bus_stb && (bus_addr == ZERO_OFS);
        dec.one  = bus_stb && (bus_addr == ONE_OFS);
        dec.data = bus_stb && (bus_addr == DATA_OFS);
        dec.rd   = bus_rd;
    end

    assign key_stb   = (state == ST_LOCKED) && (dec.zero || dec.one);
    assign key_val   = dec.one;
    assign restart   = (state == ST_LOCKED) && dec.data;
    assign shift_out = (state == ST_ARMED || state == ST_READ) && dec.data && dec.rd;
    assign shift_in  = (state == ST_ARMED || state == ST_WRITE) && (dec.zero || dec.one);
    assign rd_bit    = shift_out ? out_bit : 1'b0;

    srtc_key_match #(.KEY_BITS(KEY_BITS)) u_match (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (key_stb),
        .bit_val (key_val),
        .restart (restart),
        .hit     (hit),
        .idx     (key_idx)
    );

    srtc_xfer #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .RESET_VAL (TIME_RESET)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .load      (hit),
        .shift_out (shift_out),
        .shift_in  (shift_in),
        .in_bit    (dec.one),
        .out_bit   (out_bit),
        .done      (done),
        .commit    (commit),
        .regs      (regs)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_LOCKED: if (hit)        state_nx = ST_ARMED;
            ST_ARMED: begin
                if (shift_out)         state_nx = ST_READ;
                else if (shift_in)     state_nx = ST_WRITE;
            end
            ST_READ:   if (done)       state_nx = ST_LOCKED;
            ST_WRITE:  if (done)       state_nx = ST_LOCKED;
            default:                   state_nx = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCKED;
        else     state <= state_nx;
    end
endmodule

// File: rtl/srtc_checker.sv
module srtc_checker (
    input logic                  clk,
    input logic                  rst,
    input srtc_pkg::srtc_state_e state,
    input logic                  hit,
    input logic                  done,
    input logic                  commit,
    input logic [63:0]           regs,
    input logic                  rd_bit,
    input logic                  key_stb,
    input logic                  key_val,
    input logic [5:0]            key_idx
);
    import srtc_pkg::*;

    assert_unlock_R1: assert property (@(posedge clk) disable iff (rst)
        hit |=> (state == ST_ARMED));

    assert_locked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED) |-> !rd_bit);

    assert_mismatch_R3: assert property (@(posedge clk) disable iff (rst)
        (key_stb && (key_val != key_bit(32'(key_idx)))) |=> (key_idx == 6'd0));

    assert_regs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(regs));

    assert_relock_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> (state == ST_LOCKED));
endmodule

bind stealth_rtc srtc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .hit     (hit),
    .done    (done),
    .commit  (commit),
    .regs    (regs),
    .rd_bit  (rd_bit),
    .key_stb (key_stb),
    .key_val (key_val),
    .key_idx (key_idx)
);

// File: tb/test_stealth_rtc.sv
module test_stealth_rtc;
    localparam logic [2:0]  A_ZERO = 3'd0;
    localparam logic [2:0]  A_ONE  = 3'd1;
    localparam logic [2:0]  A_DATA = 3'd4;
    localparam logic [63:0] KEY    = 64'h5CA33AC5_5CA33AC5;
    localparam logic [63:0] RST_V  = 64'h00010101_00000000;
    localparam logic [63:0] WV     = 64'h26123105_23595859;
    localparam logic [63:0] XV     = 64'h99073002_11304217;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_stb = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       rd_bit;
    int         n_checks = 0;
    int         n_fails  = 0;

    always #5 clk = ~clk;

    stealth_rtc i_stealth_rtc (
        .clk(clk), .rst(rst), .bus_stb(bus_stb),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .rd_bit(rd_bit)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] a, input logic rd, output logic got);
        @(negedge clk);
        bus_stb = 1'b1; bus_addr = a; bus_rd = rd;
        #2 got = rd_bit;
        @(posedge clk);
        #1 bus_stb = 1'b0;
    endtask

    task automatic send_key(input int first, input int last, input int flip);
        logic g;
        for (int i = first; i <= last; i++) begin
            logic b = KEY[i] ^ (i == flip);
            access(b ? A_ONE : A_ZERO, 1'b1, g);
        end
    endtask

    task automatic read_frame(output logic [63:0] v);
        logic g;
        for (int i = 0; i < 64; i++) begin
            access(A_DATA, 1'b1, g);
            v[i] = g;
        end
    endtask

    task automatic write_frame(input logic [63:0] v, input int first, input int last);
        logic g;
        for (int i = first; i <= last; i++) access(v[i] ? A_ONE : A_ZERO, 1'b0, g);
    endtask

    task automatic data_probe(input string req);
        logic g;
        access(A_DATA, 1'b1, g);
        check(req, {63'd0, g}, 64'd0);
    endtask

    // R2 R10: locked and idle outputs after reset
    task automatic t_reset;
        @(negedge clk); #2;
        check("R10 idle output", {63'd0, rd_bit}, 64'd0);
        data_probe("R2 locked data read");
    endtask

    // R1 R5 R9 R7: unlock, read reset values, relock
    task automatic t_read_reset;
        logic [63:0] v;
        send_key(0, 63, -1);
        read_frame(v);
        check("R9 R5 R1 reset frame", v, RST_V);
        data_probe("R7 relock after read");
    endtask

    // R6 R7: write a frame, relock, read back
    task automatic t_write;
        logic [63:0] v;
        send_key(0, 63, -1);
        write_frame(WV, 0, 63);
        data_probe("R7 relock after write");
        send_key(0, 63, -1);
        read_frame(v);
        check("R6 written frame", v, WV);
    endtask

    // R3: a flipped key bit prevents unlock; a clean key afterwards works
    task automatic t_mismatch;
        logic [63:0] v;
        send_key(0, 63, 10);
        data_probe("R3 no unlock after bad bit");
        send_key(0, 9, -1);
        send_key(10, 10, 10);
        send_key(0, 63, -1);
        read_frame(v);
        check("R3 clean key after mismatch", v, WV);
    endtask

    // R4: a data access while locked restarts the matcher
    task automatic t_restart;
        logic [63:0] v;
        send_key(0, 39, -1);
        data_probe("R4 data access while locked");
        send_key(40, 63, -1);
        data_probe("R4 tail alone does not unlock");
        send_key(0, 39, -1);
        data_probe("R4 second partial key");
        send_key(0, 63, -1);
        read_frame(v);
        check("R4 full key after restart", v, WV);
    endtask

    // R8: foreign accesses during a transfer are ignored
    task automatic t_ignore;
        logic [63:0] v;
        logic g;
        send_key(0, 63, -1);
        for (int i = 0; i < 10; i++) begin access(A_DATA, 1'b1, g); v[i] = g; end
        access(A_ONE, 1'b1, g);
        access(A_ZERO, 1'b0, g);
        for (int i = 10; i < 64; i++) begin access(A_DATA, 1'b1, g); v[i] = g; end
        check("R8 bit strobes ignored in read", v, WV);
        send_key(0, 63, -1);
        write_frame(XV, 0, 19);
        access(A_DATA, 1'b1, g);
        check("R8 data read ignored in write", {63'd0, g}, 64'd0);
        write_frame(XV, 20, 63);
        send_key(0, 63, -1);
        read_frame(v);
        check("R8 R6 frame after ignored read", v, XV);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_read_reset();
        t_write();
        t_mismatch();
        t_restart();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule